// File: doc/BRIEF.md
# Vector Register Configuration Control Unit

This unit keeps the configuration of a vector register file: for each of the 32 data registers it holds a 4-bit maximum element width code and a 4-bit current element type code. It also holds the number of predicate registers in use, from 0 to 8. Software writes one field at a time through a small write port. `wr_sel` picks the kind of field, `wr_reg` picks the register and `wr_data` carries a 4-bit code. The unit checks each write and rejects any write that is not allowed. A rejected write only raises a one-cycle illegal flag, which the trap logic picks up.

An accepted write tells the data and predicate storage what to reset. Width writes and predicate-count writes reconfigure the whole unit: every data register is zeroed, all enabled predicate bits are set, and the vector length register is reloaded. A type write zeroes only the one register it names. The unit also derives the maximum vector length (MVL) from the enabled widths and a parameter that gives the physical storage size. Every side effect appears as a registered one-cycle pulse in the cycle after the write.

Top module: `vcfg_csr_unit`

## Requirements
- R1: While reset is active and after it is released, both configuration vectors, `pred_cnt`, `mvl` and every pulse output are zero.
- R2: A legal write with `wr_sel`=00 (width write) to register N stores a width code in bits 4N+3..4N of `width_cfg`. The type codes F16=0001, F32=0010, F64=0011 and F128=0100 are stored as 1001, 1010, 1011 and 1100. The codes 0000 (disabled) and 1000..1100 (8..128 bit integer) are stored unchanged. The full written code goes to the same bits of `type_cfg`.
- R3: In the cycle after a legal width write, `data_clr_all` and `vl_load` are high for that cycle. In the same cycle `pred_set_mask` has its low `pred_cnt` bits set and its other bits clear.
- R4: A write with `wr_sel`=01 (type write) is legal when its code is a known type whose width code is no larger than register N's current width code. It changes only register N's `type_cfg` bits. In the next cycle `data_clr_one` pulses with `data_clr_idx`=N, and there is no `vl_load`. `width_cfg` and `mvl` stay unchanged. At all other times `data_clr_idx` is 0.
- R5: A write with `wr_sel`=10 sets `pred_cnt` to a value from 0 to 8 and has the same pulses as R3, using the new count.
- R6: The following writes are illegal:
  - reserved codes 0101, 0110, 0111, 1101, 1110 and 1111;
  - a width write whose width code exceeds `MAX_WIDTH_CODE` (default 1011, 64 bits);
  - a type write wider than the register's current width;
  - a predicate count above 8;
  - `wr_sel`=11.

  An illegal write raises `illegal` for one cycle in the next cycle. It changes no state and produces no other pulse.
- R7: MVL is 0 when all registers are disabled. Otherwise it is the largest power of two not above `PHYS_BITS` divided by the sum of the enabled element widths, where width code 1000+k means 8<<k bits. It is never below 4. It is valid in the cycle `vl_load` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request valid |
| wr_sel | input | 2 | Field kind: 00 width, 01 type, 10 predicate count, 11 reserved |
| wr_reg | input | 5 | Target data register index |
| wr_data | input | 4 | Code or count to write |
| illegal | output | 1 | One-cycle pulse for a rejected write |
| data_clr_all | output | 1 | Zero all data registers |
| data_clr_one | output | 1 | Zero the register named by data_clr_idx |
| data_clr_idx | output | 5 | Register index for data_clr_one |
| pred_set_mask | output | 8 | Predicate registers to fill with ones |
| vl_load | output | 1 | Load vector length with mvl |
| mvl | output | 11 | Current maximum vector length |
| width_cfg | output | 128 | Width codes, register N at bits 4N+3..4N |
| type_cfg | output | 128 | Type codes, same layout |
| pred_cnt | output | 4 | Enabled predicate register count |

## Verification
The configuration vectors are visible at the ports, so any wrong stored field shows up in the cycle right after the write. An `mvl` value computed from a corrupted sum is also wrong in that same cycle.

Errors in the pulse logic show up in the same cycle as errors in the stored fields. A wrong legality decision shows either as a missing `illegal` pulse together with a changed field, or as a spurious pulse with the fields frozen. A clear of the wrong scope shows as `data_clr_all` where `data_clr_one` was expected, or as the wrong `data_clr_idx`. Idle cycles are checked too, so a pulse that lasts longer than one cycle is caught one cycle later.

// File: rtl/vcfg_pkg.sv
package vcfg_pkg;

   localparam int unsigned CODE_W = 4;

   typedef enum logic [1:0] {
      SEL_WIDTH = 2'd0,
      SEL_TYPE  = 2'd1,
      SEL_PRED  = 2'd2,
      SEL_RSVD  = 2'd3
   } cfg_sel_e;

   // A code is known when it is disabled, a float type or an integer type.
   function automatic logic code_known(input logic [CODE_W-1:0] c);
      return (c <= 4'h4) || ((c >= 4'h8) && (c <= 4'hC));
   endfunction

   // Width-only projection of a type code: floats map onto the integer width code.
   function automatic logic [CODE_W-1:0] width_of(input logic [CODE_W-1:0] c);
      if ((c >= 4'h1) && (c <= 4'h4)) return c + 4'h8;
      return c;
   endfunction

   // Element size in bits for a stored width code.
   function automatic logic [31:0] elem_bits(input logic [CODE_W-1:0] w);
      if ((w >= 4'h8) && (w <= 4'hC)) return 32'd8 << (w - 4'h8);
      return 32'd0;
   endfunction

endpackage

// File: rtl/vcfg_check.sv
module vcfg_check
   import vcfg_pkg::*;
#(
   parameter logic [3:0]  MAX_WIDTH_CODE = 4'hB,
   parameter int unsigned NPRED          = 8
) (
   input  cfg_sel_e           sel,
   input  logic [CODE_W-1:0]  code,
   input  logic [CODE_W-1:0]  cur_width,
   output logic               legal,
   output logic [CODE_W-1:0]  proj
);

   always_comb begin
      proj = width_of(code);
      unique case (sel)
         SEL_WIDTH: legal = code_known(code) && (proj <= MAX_WIDTH_CODE);
         SEL_TYPE:  legal = code_known(code) && (proj <= cur_width);
         SEL_PRED:  legal = (32'(code) <= NPRED);
         default:   legal = 1'b0;
      endcase
   end

endmodule

// File: rtl/vcfg_fields.sv
module vcfg_fields
   import vcfg_pkg::*;
#(
   parameter int unsigned NREG  = 32,
   parameter int unsigned IDX_W = $clog2(NREG)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     set_both,
   input  logic                     set_type,
   input  logic [IDX_W-1:0]         idx,
   input  logic [CODE_W-1:0]        width_code,
   input  logic [CODE_W-1:0]        type_code,
   output logic [NREG*CODE_W-1:0]   width_vec,
   output logic [NREG*CODE_W-1:0]   type_vec
);

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [CODE_W-1:0] w_q, t_q;
      logic              hit;

      assign hit = (idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            w_q <= '0;
            t_q <= '0;
         end else if (hit && set_both) begin
            w_q <= width_code;
            t_q <= type_code;
         end else if (hit && set_type) begin
            t_q <= type_code;
         end
      end

      assign width_vec[g*CODE_W +: CODE_W] = w_q;
      assign type_vec[g*CODE_W +: CODE_W]  = t_q;

      // A stored type never needs more bits than the register's width (R4)
      p_type_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
         width_of(t_q) <= w_q);
   end

endmodule

// File: rtl/vcfg_mvl.sv
module vcfg_mvl
   import vcfg_pkg::*;
#(
   parameter int unsigned NREG      = 32,
   parameter int unsigned PHYS_BITS = 8192,
   parameter int unsigned MVL_W     = 11
) (
   input  logic [NREG*CODE_W-1:0] width_vec,
   output logic [MVL_W-1:0]       mvl
);

   localparam int unsigned MAXK = $clog2(PHYS_BITS / 8);

   logic [31:0] ebits [NREG];
   logic [31:0] total;
   logic [31:0] best;

   for (genvar g = 0; g < NREG; g++) begin : g_ebits
      assign ebits[g] = elem_bits(width_vec[g*CODE_W +: CODE_W]);
   end

   always_comb begin
      total = '0;
      for (int i = 0; i < NREG; i++) total = total + ebits[i];
      best = '0;
      for (int k = 0; k <= MAXK; k++) begin
         if ((total << k) <= PHYS_BITS) best = 32'd1 << k;
      end
      if (total == 32'd0)     mvl = '0;
      else if (best < 32'd4)  mvl = MVL_W'(4);
      else                    mvl = best[MVL_W-1:0];
   end

endmodule

// File: rtl/vcfg_csr_unit.sv
module vcfg_csr_unit
   import vcfg_pkg::*;
#(
   parameter int unsigned NREG           = 32,
   parameter int unsigned NPRED          = 8,
   parameter int unsigned PHYS_BITS      = 8192,
   parameter logic [3:0]  MAX_WIDTH_CODE = 4'hB,
   localparam int unsigned IDX_W = $clog2(NREG),
   localparam int unsigned CFG_W = NREG * CODE_W,
   localparam int unsigned MVL_W = $clog2(PHYS_BITS / 8) + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [IDX_W-1:0]   wr_reg,
   input  logic [3:0]         wr_data,
   output logic               illegal,
   output logic               data_clr_all,
   output logic               data_clr_one,
   output logic [IDX_W-1:0]   data_clr_idx,
   output logic [NPRED-1:0]   pred_set_mask,
   output logic               vl_load,
   output logic [MVL_W-1:0]   mvl,
   output logic [CFG_W-1:0]   width_cfg,
   output logic [CFG_W-1:0]   type_cfg,
   output logic [3:0]         pred_cnt
);

   initial begin
      assert (NPRED >= 1 && NPRED <= 8) else $error("NPRED must be 1..8");
      assert (NREG >= 2) else $error("NREG must be at least 2");
      assert (PHYS_BITS >= 32) else $error("PHYS_BITS too small for MVL of 4");
      assert (MAX_WIDTH_CODE >= 4'h8 && MAX_WIDTH_CODE <= 4'hC)
         else $error("MAX_WIDTH_CODE must be an enabled width code");
   end

   cfg_sel_e          sel_e;
   logic [3:0]        cur_width;
   logic              legal;
   logic [3:0]        proj;
   logic              accept, reject;
   logic              set_both, set_type, set_pred, reconfig;
   logic [3:0]        next_pcnt;
   logic [NPRED-1:0]  next_mask;

   assign sel_e     = cfg_sel_e'(wr_sel);
   assign cur_width = width_cfg[{wr_reg, 2'b00} +: 4];

   vcfg_check #(
      .MAX_WIDTH_CODE (MAX_WIDTH_CODE),
      .NPRED          (NPRED)
   ) u_check (
      .sel       (sel_e),
      .code      (wr_data),
      .cur_width (cur_width),
      .legal     (legal),
      .proj      (proj)
   );

   assign accept   = wr_en && legal;
   assign reject   = wr_en && !legal;
   assign set_both = accept && (sel_e == SEL_WIDTH);
   assign set_type = accept && (sel_e == SEL_TYPE);
   assign set_pred = accept && (sel_e == SEL_PRED);
   assign reconfig = set_both || set_pred;

   vcfg_fields #(
      .NREG  (NREG),
      .IDX_W (IDX_W)
   ) u_fields (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_both   (set_both),
      .set_type   (set_type),
      .idx        (wr_reg),
      .width_code (proj),
      .type_code  (wr_data),
      .width_vec  (width_cfg),
      .type_vec   (type_cfg)
   );

   vcfg_mvl #(
      .NREG      (NREG),
      .PHYS_BITS (PHYS_BITS),
      .MVL_W     (MVL_W)
   ) u_mvl (
      .width_vec (width_cfg),
      .mvl       (mvl)
   );

   assign next_pcnt = set_pred ? wr_data : pred_cnt;

   for (genvar g = 0; g < NPRED; g++) begin : g_mask
      assign next_mask[g] = (32'(next_pcnt) > g);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pred_cnt      <= '0;
         illegal       <= 1'b0;
         data_clr_all  <= 1'b0;
         data_clr_one  <= 1'b0;
         data_clr_idx  <= '0;
         pred_set_mask <= '0;
         vl_load       <= 1'b0;
      end else begin
         pred_cnt      <= next_pcnt;
         illegal       <= reject;
         data_clr_all  <= reconfig;
         data_clr_one  <= set_type;
         data_clr_idx  <= set_type ? wr_reg : '0;
         pred_set_mask <= reconfig ? next_mask : '0;
         vl_load       <= reconfig;
      end
   end

   // Rejected write leaves everything untouched (R6)
   p_reject_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (width_cfg == $past(width_cfg) && type_cfg == $past(type_cfg) &&
                   pred_cnt == $past(pred_cnt) && !data_clr_all && !data_clr_one && !vl_load));

   // Vector length reload comes only with a full clear (R3)
   p_vl_with_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vl_load |-> data_clr_all);

   // Type write keeps widths and MVL (R4)
   p_type_keeps_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      data_clr_one |-> (width_cfg == $past(width_cfg) && mvl == $past(mvl) && !vl_load));

   // Only one kind of outcome per write (R6)
   p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({illegal, data_clr_all, data_clr_one}));

   // Predicate count stays in range (R5)
   p_pred_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(pred_cnt) <= NPRED);

   // Predicate fill matches the count (R5)
   p_mask_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      data_clr_all |-> ($countones(pred_set_mask) == 32'(pred_cnt)));

   // MVL floor when configured, zero when not (R7)
   p_mvl_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|width_cfg) |-> (mvl >= MVL_W'(4)));
   p_mvl_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(|width_cfg) |-> (mvl == '0));

endmodule

// File: tb/sim_vcfg_csr_unit.sv
module sim_vcfg_csr_unit;

   localparam int CLK_PER = 10;

   typedef struct {
      string        req;
      logic         ill;
      logic         clr_all;
      logic         clr_one;
      logic [4:0]   idx;
      logic [7:0]   mask;
      logic         vl;
      logic [10:0]  mvl;
      logic [127:0] wcfg;
      logic [127:0] tcfg;
      logic [3:0]   pcnt;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         wr_en;
   logic [1:0]   wr_sel;
   logic [4:0]   wr_reg;
   logic [3:0]   wr_data;
   logic         illegal, data_clr_all, data_clr_one, vl_load;
   logic [4:0]   data_clr_idx;
   logic [7:0]   pred_set_mask;
   logic [10:0]  mvl;
   logic [127:0] width_cfg, type_cfg;
   logic [3:0]   pred_cnt;

   int nchk = 0;
   int nerr = 0;
   logic mon_on = 1'b0;
   exp_t q[$];

   logic [3:0] m_w [32];
   logic [3:0] m_t [32];
   int         m_p;

   always #(CLK_PER/2) clk = ~clk;

   vcfg_csr_unit u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_reg(wr_reg),
      .wr_data(wr_data), .illegal(illegal), .data_clr_all(data_clr_all),
      .data_clr_one(data_clr_one), .data_clr_idx(data_clr_idx),
      .pred_set_mask(pred_set_mask), .vl_load(vl_load), .mvl(mvl),
      .width_cfg(width_cfg), .type_cfg(type_cfg), .pred_cnt(pred_cnt)
   );

   function automatic logic [3:0] wproj(logic [3:0] c);
      case (c)
         4'h1: return 4'h9;
         4'h2: return 4'hA;
         4'h3: return 4'hB;
         4'h4: return 4'hC;
         default: return c;
      endcase
   endfunction

   function automatic logic known(logic [3:0] c);
      return c inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC};
   endfunction

   function automatic logic [10:0] model_mvl();
      int sum = 0;
      int qt, p;
      for (int i = 0; i < 32; i++)
         if (m_w[i] >= 4'h8) sum += 8 << (m_w[i] - 4'h8);
      if (sum == 0) return 11'd0;
      qt = 8192 / sum;
      p = 1;
      while (p * 2 <= qt) p = p * 2;
      if (p < 4) p = 4;
      return 11'(p);
   endfunction

   function automatic logic [127:0] pack_w();
      logic [127:0] v;
      for (int i = 0; i < 32; i++) v[i*4 +: 4] = m_w[i];
      return v;
   endfunction

   function automatic logic [127:0] pack_t();
      logic [127:0] v;
      for (int i = 0; i < 32; i++) v[i*4 +: 4] = m_t[i];
      return v;
   endfunction

   task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_write(logic [1:0] sel, logic [4:0] r, logic [3:0] d, string req);
      exp_t e;
      logic ok;
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_reg = r; wr_data = d;
      case (sel)
         2'd0: ok = known(d) && (wproj(d) <= 4'hB);
         2'd1: ok = known(d) && (wproj(d) <= m_w[r]);
         2'd2: ok = (d <= 4'd8);
         default: ok = 1'b0;
      endcase
      e.req = req; e.ill = !ok; e.clr_all = 1'b0; e.clr_one = 1'b0;
      e.idx = 5'd0; e.mask = 8'd0; e.vl = 1'b0;
      if (ok) begin
         if (sel == 2'd0) begin m_w[r] = wproj(d); m_t[r] = d; end
         if (sel == 2'd1) begin m_t[r] = d; e.clr_one = 1'b1; e.idx = r; end
         if (sel == 2'd2) m_p = int'(d);
         if (sel != 2'd1) begin
            e.clr_all = 1'b1; e.vl = 1'b1;
            e.mask = 8'((9'd1 << m_p) - 9'd1);
         end
      end
      e.mvl = model_mvl(); e.wcfg = pack_w(); e.tcfg = pack_t(); e.pcnt = 4'(m_p);
      q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Monitor: one expected item per write, checked just after the edge that registers it
   initial begin
      exp_t e;
      wait (mon_on);
      forever begin
         @(posedge clk);
         #(CLK_PER/4);
         if (q.size() > 0) begin
            e = q.pop_front();
         end else begin
            e.req = "R3 idle"; e.ill = 0; e.clr_all = 0; e.clr_one = 0; e.idx = 0;
            e.mask = 0; e.vl = 0; e.mvl = model_mvl(); e.wcfg = pack_w();
            e.tcfg = pack_t(); e.pcnt = 4'(m_p);
         end
         chk(e.req, "illegal", 128'(illegal), 128'(e.ill));
         chk(e.req, "data_clr_all", 128'(data_clr_all), 128'(e.clr_all));
         chk(e.req, "data_clr_one", 128'(data_clr_one), 128'(e.clr_one));
         chk(e.req, "data_clr_idx", 128'(data_clr_idx), 128'(e.idx));
         chk(e.req, "pred_set_mask", 128'(pred_set_mask), 128'(e.mask));
         chk(e.req, "vl_load", 128'(vl_load), 128'(e.vl));
         chk(e.req, "mvl", 128'(mvl), 128'(e.mvl));
         chk(e.req, "width_cfg", width_cfg, e.wcfg);
         chk(e.req, "type_cfg", type_cfg, e.tcfg);
         chk(e.req, "pred_cnt", 128'(pred_cnt), 128'(e.pcnt));
      end
   end

   initial begin
      #(CLK_PER * 100000);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
   end

   initial begin
      for (int i = 0; i < 32; i++) begin m_w[i] = 4'h0; m_t[i] = 4'h0; end
      m_p = 0;
      rst_n = 1'b0; wr_en = 1'b0; wr_sel = 2'd0; wr_reg = 5'd0; wr_data = 4'd0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "width_cfg", width_cfg, 128'd0);
      chk("R1", "type_cfg", type_cfg, 128'd0);
      chk("R1", "mvl", 128'(mvl), 128'd0);
      chk("R1", "pulses", 128'({illegal, data_clr_all, data_clr_one, vl_load, pred_set_mask}), 128'd0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      idle(); idle();

      do_write(2'd0, 5'd0, 4'hA, "R2 X32 v0");              idle();
      do_write(2'd2, 5'd0, 4'd3, "R5 three preds");         idle();
      do_write(2'd0, 5'd1, 4'h2, "R2 F32 v1 projection");   idle();
      do_write(2'd1, 5'd1, 4'h9, "R4 type X16 v1");         idle();
      do_write(2'd1, 5'd1, 4'hB, "R6 type wider than width"); idle();
      do_write(2'd1, 5'd5, 4'h1, "R6 type on disabled reg"); idle();
      do_write(2'd0, 5'd2, 4'hC, "R6 X128 above max");      idle();
      do_write(2'd0, 5'd2, 4'h4, "R6 F128 above max");      idle();
      do_write(2'd0, 5'd3, 4'h5, "R6 reserved 5");          idle();
      do_write(2'd0, 5'd3, 4'hF, "R6 reserved F");          idle();
      do_write(2'd2, 5'd0, 4'd9, "R6 pred count 9");        idle();
      do_write(2'd3, 5'd0, 4'h8, "R6 reserved select");     idle();
      do_write(2'd2, 5'd0, 4'd8, "R5 eight preds");         idle();
      do_write(2'd0, 5'd1, 4'h9, "R7 X32+X16 non pow2");    idle();
      // back-to-back writes
      do_write(2'd1, 5'd0, 4'h2, "R4 F32 into X32");
      do_write(2'd0, 5'd31, 4'h3, "R2 F64 v31");
      do_write(2'd1, 5'd31, 4'h0, "R4 type disable");
      idle();
      for (int i = 0; i < 32; i++) do_write(2'd0, 5'(i), 4'hB, "R7 all X64 floor");
      idle();
      for (int i = 0; i < 32; i++) do_write(2'd0, 5'(i), 4'h0, "R7 all disabled");
      idle();
      do_write(2'd2, 5'd0, 4'd0, "R5 zero preds");          idle();
      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule